// File: doc/BRIEF.md
# Burst-Grouping DMA Request Generator for a Playback Buffer

This block sits on the device side of an audio-style peripheral. A central DMA controller, which is outside the block, writes sample bytes into it. The block holds those bytes in a small first-in first-out buffer, and a sample consumer drains the buffer through a valid/ready stream port.

The request line toward the controller follows hysteresis on the buffer's fill level. The line goes high when the occupancy has sunk to a programmable low mark, and it stays high while the buffer refills. It drops one entry short of full. A controller in demand mode therefore holds the bus for a run of transfers and then gives it back. The request also drops after a fixed number of back-to-back acknowledged transfers, so that one bus tenure stays short. A controller that releases the bus after every transfer is served correctly, only with more arbitration.

The consumer port uses valid/ready rules. `smp_valid` is high whenever a sample is waiting. A sample leaves the buffer only at a rising edge where both `smp_valid` and `smp_ready` are high. While `smp_ready` is low, the head sample and `smp_valid` stay put. A consumer that asserts `smp_ready` while the buffer is empty is not stalled: it sees the last sample again, and the block records the underrun.

Top module: `dma_burst_requester`

## Requirements
- R1: When the request line is idle, `dreq` rises at the clock edge where the occupancy becomes less than or equal to the effective low mark. With an empty buffer, this is the first edge after reset is released.
- R2: A byte on `io_data` is stored at a rising edge only when `io_wr` and `dack` are both high. `io_wr` without `dack` is ignored. A write into a buffer holding DEPTH entries is discarded.
- R3: Once `dreq` is high, it stays high while the buffer fills. It falls at the edge where the occupancy reaches DEPTH-1. One further acknowledged write is still stored, which brings the occupancy to DEPTH.
- R4: In single-transfer operation, `dack` drops between transfers. This neither lowers `dreq` nor advances the burst limit, however many transfers occur.
- R5: After MAX_BURST (default 15) consecutive acknowledged writes while `dack` stays high and `dreq` is high, `dreq` falls at the edge of the last of those writes.
  - `dreq` stays low while `dack` remains high.
  - It rises again at the first edge where `dack` is sampled low, provided the occupancy is below DEPTH-1.
- R6: `smp_valid` is high exactly when the occupancy is nonzero, and `smp_data` shows the oldest stored byte. That byte is removed at an edge with `smp_valid` and `smp_ready` high. With `smp_ready` low, the head stays unchanged.
- R7: `smp_ready` while the buffer is empty removes nothing, and `smp_data` shows the most recently removed byte (zero if none). `underrun` goes high at that edge and stays high until reset.
- R8: While `rst_n` is low, `dreq`, `smp_valid` and `underrun` are low, `smp_data` is zero and the buffer is empty.
- R9: A `lo_mark` value above DEPTH-2 acts as DEPTH-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_mark | input | $clog2(DEPTH+1) | Low-mark occupancy that starts a request |
| dreq | output | 1 | DMA request toward the controller |
| dack | input | 1 | DMA acknowledge from the controller |
| io_wr | input | 1 | I/O write strobe for a DMA transfer |
| io_data | input | DW | Byte written by a DMA transfer |
| smp_valid | output | 1 | A sample is available |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | DW | Head sample, or the last sample when empty |
| underrun | output | 1 | Sticky flag: a sample was taken from an empty buffer |

## Verification
Every result is due in the cycle after the rising edge that samples its stimulus. The occupancy and the request state are both registered at that edge, so a write, a removal, a request change and an underrun all become visible together, one edge later. The bench drives inputs at the falling edge and compares every output at the next falling edge. Each check therefore lands half a cycle after the edge that should have produced the result and half a cycle before the next one. The tests that probe the burst limit and the single-transfer pattern check `dreq` after every individual transfer, so an early or late change in `dreq` shows up at the exact transfer where it happens.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE   = 2'd0,
    RQ_ACTIVE = 2'd1,
    RQ_REST   = 2'd2
  } rq_state_e;

endpackage

// File: rtl/drq_fifo.sv
module drq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cnt_nx,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          underrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [DW-1:0] last_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == FULLC);
  assign empty   = (count == '0);
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;

  always_comb begin
    cnt_nx = count;
    case ({do_push, do_pop})
      2'b10:   cnt_nx = count + CW'(1);
      2'b01:   cnt_nx = count - CW'(1);
      default: cnt_nx = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      last_q   <= '0;
      underrun <= 1'b0;
    end else begin
      count <= cnt_nx;
      if (do_push) wptr <= (wptr == LASTP) ? '0 : wptr + AW'(1);
      if (do_pop) begin
        rptr   <= (rptr == LASTP) ? '0 : rptr + AW'(1);
        last_q <= mem[rptr];
      end
      if (pop_req && empty) underrun <= 1'b1;
    end
  end

  assign valid = !empty;
  assign dout  = empty ? last_q : mem[rptr];

  // R2: an accepted write alone raises the occupancy by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full && !pop_req) |=> (count == $past(count) + CW'(1)));

  // R2: a write into a full buffer leaves it full
  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (count == FULLC));

  // R6: back-pressure holds the head sample
  p_hold_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop_req) |=> (valid && $stable(dout)));

  // R7: a read from empty repeats the last sample and flags underrun
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> (underrun && $stable(dout)));

endmodule

// File: rtl/drq_mark.sv
module drq_mark #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] lo_mark,
  output logic [CW-1:0] mark_eff
);

  localparam logic [CW-1:0] MARK_MAX = CW'(DEPTH - 2);

  assign mark_eff = (lo_mark > MARK_MAX) ? MARK_MAX : lo_mark;

endmodule

// File: rtl/drq_ctrl.sv
module drq_ctrl
  import dmareq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BURST = 15,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] mark_eff,
  input  logic          dack,
  input  logic          wr_ack,
  output logic          dreq
);

  localparam int BW = $clog2(MAX_BURST + 1) + 1;
  localparam logic [CW-1:0] STOP = CW'(DEPTH - 1);
  localparam logic [BW-1:0] BCAP = BW'(MAX_BURST);

  rq_state_e     state_q, state_nx;
  logic [BW-1:0] burst_q, burst_nx;

  always_comb begin
    if (state_q == RQ_ACTIVE && dack) burst_nx = burst_q + BW'(wr_ack);
    else                              burst_nx = '0;
  end

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      RQ_IDLE: begin
        if (cnt_nx <= mark_eff) state_nx = RQ_ACTIVE;
      end
      RQ_ACTIVE: begin
        if (cnt_nx >= STOP)         state_nx = RQ_IDLE;
        else if (burst_nx >= BCAP)  state_nx = RQ_REST;
      end
      RQ_REST: begin
        if (!dack) state_nx = (cnt_nx >= STOP) ? RQ_IDLE : RQ_ACTIVE;
      end
      default: state_nx = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      burst_q <= '0;
    end else begin
      state_q <= state_nx;
      burst_q <= burst_nx;
    end
  end

  assign dreq = (state_q == RQ_ACTIVE);

  // R1: a request started from idle only at or below the low mark
  p_rise_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RQ_ACTIVE && $past(state_q) == RQ_IDLE) |-> (count <= mark_eff));

  // R4: a released bus below the stop level keeps the request up
  p_single_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !dack && cnt_nx < STOP) |=> dreq);

  // R5: while resting with the bus still held, no request
  p_rest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RQ_REST && dack) |=> !dreq);

endmodule

// File: rtl/dma_burst_requester.sv
module dma_burst_requester #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int MAX_BURST = 15,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] lo_mark,
  output logic          dreq,
  input  logic          dack,
  input  logic          io_wr,
  input  logic [DW-1:0] io_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic          underrun
);

  localparam int RW = $clog2(MAX_BURST + 2) + 1;

  logic          wr_ack;
  logic [CW-1:0] count, cnt_nx, mark_eff;

  assign wr_ack = io_wr && dack;

  drq_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_ack),
    .din      (io_data),
    .pop_req  (smp_ready),
    .count    (count),
    .cnt_nx   (cnt_nx),
    .valid    (smp_valid),
    .dout     (smp_data),
    .underrun (underrun)
  );

  drq_mark #(.DEPTH(DEPTH), .CW(CW)) u_mark (
    .lo_mark  (lo_mark),
    .mark_eff (mark_eff)
  );

  drq_ctrl #(.DEPTH(DEPTH), .MAX_BURST(MAX_BURST), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .cnt_nx   (cnt_nx),
    .mark_eff (mark_eff),
    .dack     (dack),
    .wr_ack   (wr_ack),
    .dreq     (dreq)
  );

  // R3: never requesting with the buffer at or above the stop level
  p_stop_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CW'(DEPTH - 1)) |-> !dreq);

  // R5: run of acknowledged writes during one request never exceeds the cap
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!dack || !dreq)  run_q <= '0;
    else if (io_wr)           run_q <= run_q + RW'(1);
  end

  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(MAX_BURST));

endmodule

// File: tb/dma_burst_requester_bench.sv
`timescale 1ns/100ps
module dma_burst_requester_bench;

  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int MAX_BURST = 15;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] lo_mark = CW'(4);
  logic          dreq, dack = 1'b0, io_wr = 1'b0;
  logic [DW-1:0] io_data = '0;
  logic          smp_valid, smp_ready = 1'b0, underrun;
  logic [DW-1:0] smp_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_burst_requester #(.DW(DW), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) u_dma_burst_requester (
    .clk(clk), .rst_n(rst_n), .lo_mark(lo_mark), .dreq(dreq), .dack(dack),
    .io_wr(io_wr), .io_data(io_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .underrun(underrun)
  );

  typedef struct packed {
    logic       wr;
    logic       ack;
    logic [7:0] d;
    logic       rdy;
    logic       e_dreq;
    logic       e_valid;
    logic [7:0] e_data;
    logic       e_unf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // R1 request after reset
    '{1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0},  // R2 write
    '{1'b1, 1'b1, 8'h22, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0},  // R6 head held
    '{1'b1, 1'b0, 8'h99, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0},  // R2 no dack, ignored
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h22, 1'b0},  // R6 pop
    '{1'b1, 1'b1, 8'h33, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0},  // R6 push and pop
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h33, 1'b0},  // R6 drained
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h33, 1'b1},  // R7 empty read
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h33, 1'b1}   // R7 sticky
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic a, input logic [7:0] d, input logic r);
    io_wr = w; dack = a; io_data = d; smp_ready = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [CW-1:0] mark);
    rst_n = 1'b0; io_wr = 1'b0; dack = 1'b0; io_data = '0; smp_ready = 1'b0;
    lo_mark = mark;
    repeat (2) @(negedge clk);
    check("R8 dreq in reset", dreq, 0);
    check("R8 valid in reset", smp_valid, 0);
    check("R8 data in reset", smp_data, 0);
    check("R8 underrun in reset", underrun, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(CW'(4));

    // vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].ack, VEC[i].d, VEC[i].rdy);
      check("R1/R2/R6 vector dreq", dreq, VEC[i].e_dreq);
      check("R6 vector valid", smp_valid, VEC[i].e_valid);
      check("R6/R7 vector data", smp_data, VEC[i].e_data);
      check("R7 vector underrun", underrun, VEC[i].e_unf);
    end

    // R3: fill with dack held, stop one short of full, absorb in-flight write
    do_reset(CW'(4));
    step(0, 0, 8'h00, 0);
    check("R1 first edge request", dreq, 1);
    for (int i = 0; i < 15; i++) begin
      step(1, 1, 8'(8'h40 + i), 0);
      check("R3 dreq during fill", dreq, (i < 14) ? 1 : 0);
    end
    step(1, 1, 8'h4F, 0);
    check("R3 in-flight write dreq", dreq, 0);
    step(1, 1, 8'hEE, 0);
    check("R2 write into full dreq", dreq, 0);
    io_wr = 0; dack = 0;
    for (int p = 1; p <= 16; p++) begin
      check("R6 drain order", smp_data, 8'(8'h40 + p - 1));
      check("R6 drain valid", smp_valid, 1);
      step(0, 0, 8'h00, 1);
      check("R1 request at low mark", dreq, ((16 - p) <= 4) ? 1 : 0);
    end
    check("R2 full write discarded", smp_valid, 0);
    check("R7 no underrun on drain", underrun, 0);

    // R4: single transfers with bus released between them
    do_reset(CW'(4));
    step(0, 0, 8'h00, 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 8'(8'h80 + i), 0);
      check("R4 dreq after transfer", dreq, 1);
      check("R4 data stored", smp_data, 8'(8'h80 + i));
      step(0, 0, 8'h00, 1);
      check("R4 dreq in gap", dreq, 1);
    end
    check("R4 no underrun", underrun, 0);

    // R5: burst cap with consumer draining in parallel
    do_reset(CW'(4));
    step(0, 0, 8'h00, 0);
    step(1, 1, 8'h10, 0);
    check("R5 first write dreq", dreq, 1);
    for (int i = 1; i < 15; i++) begin
      step(1, 1, 8'(8'h10 + i), 1);
      check("R5 dreq in burst", dreq, (i < 14) ? 1 : 0);
      check("R5 head follows", smp_data, 8'(8'h10 + i));
    end
    step(0, 1, 8'h00, 0);
    check("R5 low while dack held", dreq, 0);
    step(0, 0, 8'h00, 0);
    check("R5 re-request after release", dreq, 1);

    // R9: threshold above DEPTH-2 clamps
    do_reset(CW'(31));
    step(0, 0, 8'h00, 0);
    for (int i = 0; i < 15; i++) step(1, 1, 8'(i), 0);
    check("R9 stop at fifteen", dreq, 0);
    step(0, 0, 8'h00, 0);
    check("R9 still idle at fifteen", dreq, 0);
    step(0, 0, 8'h00, 1);
    check("R9 request at clamped mark", dreq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule